// File: doc/BRIEF.md
# Two-Bit-Opcode Accumulator Processor Core

This core is a single-address accumulator machine. Data words and instruction words are both 18 bits wide. An instruction holds a 2-bit operation code in bits 17:16 and a 16-bit field in bits 15:0. Three of the four operations treat the field as a word address, which gives an address space of 65,536 words. These operations are store accumulator, add to accumulator and conditional jump. The fourth operation, "operate", uses no address. Its 16 field bits are independent enables for primitive register actions: clearing, complementing, moving a word between the accumulator and a second "link" register, halting, and switching a set of device enable outputs on and off.

The core drives one synchronous memory port. The memory registers the address in one cycle and presents the read word in the next cycle. Writes happen on the clock edge at which write enable is high. Every instruction takes one fetch cycle and one execute cycle. The operand read of an add overlaps the fetch of the next instruction. After reset the core is halted with the program counter at 0. A start pulse sets it running. An operate instruction with its halt bit set stops it again, and a later start pulse resumes at the next address.

Top module: `acc_core`

## Requirements
- R1: The operation code is in bits 17:16 and is encoded as follows: 00 store, 01 add, 10 conditional jump, 11 operate. Bits 15:0 are the field.
- R2: Add sets AC to AC plus the word at the field address, computed as an 18-bit one's-complement sum: a carry out of bit 17 is added back in at bit 0.
- R3: Store writes AC to the field address. Write enable is high for exactly one cycle per store.
- R4: Conditional jump loads the program counter with the field when AC bit 17 is 1. Otherwise the program counter increments, as it does for every other non-halting instruction.
- R5: Operate field bits 0 to 4 are: clear AC (bit 0), clear link (bit 1), copy AC to link (bit 2), copy link to AC (bit 3), complement AC (bit 4). They act in this order: first the clears, then both copies (each sampling the post-clear values, so setting both bits swaps the registers), then the complement.
- R6: Operate bit 5 halts the core after that instruction. A halted core makes no memory writes and stays halted until a start pulse, then resumes at the following address. Reset halts the core and clears the program counter, AC, link and device enables.
- R7: Operate bit 6+k switches device enable k on and bit 11+k switches it off, for k = 0..4. When both bits are set, off wins. Enables hold their value between operate instructions.
- R8: Every instruction takes exactly two cycles, so a run of N executed instructions ending in a halt keeps running_o high for 2N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, acted on only while halted |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 18 | Memory write data (accumulator) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 18 | Memory read data, valid one cycle after its address |
| running_o | output | 1 | High while the core executes |
| dev_en_o | output | 5 | Device enable outputs |

## Verification
The adder is tested with sums that produce no carry, sums that produce an end-around carry (minus one plus five), a sum that crosses into the sign bit, and x plus minus x giving minus zero. These cases separate one's-complement behaviour from plain two's-complement wrapping. Operate words combine clear with copy, clear with complement, and both copies at once. The AC values chosen before each of these make every wrong ordering of the phases give a different stored result. Jumps are tried with a negative AC and with a zero AC, and sentinel words show which path was taken. Device words set, clear, and set-and-clear the same enable across separate halt and resume runs.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 2;
  localparam int N_DEV = 5;

  typedef enum logic [1:0] {
    OP_STO = 2'b00,
    OP_ADD = 2'b01,
    OP_JMP = 2'b10,
    OP_OPR = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } state_e;

  // operate field bit positions
  localparam int MB_CLA  = 0;
  localparam int MB_CLL  = 1;
  localparam int MB_A2L  = 2;
  localparam int MB_L2A  = 3;
  localparam int MB_CMA  = 4;
  localparam int MB_HLT  = 5;
  localparam int MB_DON  = 6;
  localparam int MB_DOFF = MB_DON + N_DEV;
endpackage

// File: rtl/acc_oc_adder.sv
module acc_oc_adder #(
  parameter int W = 18
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    // end-around carry
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/acc_microop.sv
module acc_microop
  import acc_pkg::*;
#(
  parameter int W       = 18,
  parameter int FIELD_W = 16
) (
  input  logic [W-1:0]       ac_i,
  input  logic [W-1:0]       lr_i,
  input  logic [FIELD_W-1:0] ctl_i,
  input  logic [N_DEV-1:0]   dev_i,
  output logic [W-1:0]       ac_o,
  output logic [W-1:0]       lr_o,
  output logic [N_DEV-1:0]   dev_o,
  output logic               halt_o
);
  logic [W-1:0] ac_clr, lr_clr, ac_xfr;

  always_comb begin
    ac_clr = ctl_i[MB_CLA] ? '0 : ac_i;
    lr_clr = ctl_i[MB_CLL] ? '0 : lr_i;
    // both copies sample post-clear values: setting both swaps
    lr_o   = ctl_i[MB_A2L] ? ac_clr : lr_clr;
    ac_xfr = ctl_i[MB_L2A] ? lr_clr : ac_clr;
    ac_o   = ctl_i[MB_CMA] ? ~ac_xfr : ac_xfr;
    halt_o = ctl_i[MB_HLT];
  end

  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    assign dev_o[k] = (dev_i[k] | ctl_i[MB_DON+k]) & ~ctl_i[MB_DOFF+k];
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  opcode_e           op_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic              ac_sign_i,
  input  logic              halt_i,
  output state_e            state_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic take_jump;

  assign take_jump = (op_i == OP_JMP) && ac_sign_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_HALT;
      pc_o    <= '0;
    end else begin
      unique case (state_o)
        ST_HALT:  if (start_i) state_o <= ST_FETCH;
        ST_FETCH: state_o <= ST_EXEC;
        ST_EXEC: begin
          pc_o    <= take_jump ? field_i : pc_o + 1'b1;
          state_o <= (op_i == OP_OPR && halt_i) ? ST_HALT : ST_FETCH;
        end
        default:  state_o <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter  int ADDR_W = 16,
  localparam int DATA_W = ADDR_W + acc_pkg::OPC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic                    mem_we_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    running_o,
  output logic [acc_pkg::N_DEV-1:0] dev_en_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ac_q, lr_q, sum, mo_ac, mo_lr;
  logic [N_DEV-1:0]  dev_q, mo_dev;
  logic              add_pend_q, mo_halt, is_exec;
  opcode_e           op;
  logic [ADDR_W-1:0] field;

  // in EXEC the read port carries the instruction, in FETCH the pending operand
  assign is_exec = (state_q == ST_EXEC);
  assign op      = opcode_e'(mem_rdata_i[DATA_W-1 -: OPC_W]);
  assign field   = mem_rdata_i[ADDR_W-1:0];

  acc_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (op),
    .field_i   (field),
    .ac_sign_i (ac_q[DATA_W-1]),
    .halt_i    (mo_halt),
    .state_o   (state_q),
    .pc_o      (pc_q)
  );

  acc_oc_adder #(.W(DATA_W)) i_adder (
    .a_i   (ac_q),
    .b_i   (mem_rdata_i),
    .sum_o (sum)
  );

  acc_microop #(.W(DATA_W), .FIELD_W(ADDR_W)) i_microop (
    .ac_i   (ac_q),
    .lr_i   (lr_q),
    .ctl_i  (field),
    .dev_i  (dev_q),
    .ac_o   (mo_ac),
    .lr_o   (mo_lr),
    .dev_o  (mo_dev),
    .halt_o (mo_halt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q       <= '0;
      lr_q       <= '0;
      dev_q      <= '0;
      add_pend_q <= 1'b0;
    end else begin
      add_pend_q <= is_exec && (op == OP_ADD);
      if (state_q == ST_FETCH && add_pend_q) ac_q <= sum;
      if (is_exec && op == OP_OPR) begin
        ac_q  <= mo_ac;
        lr_q  <= mo_lr;
        dev_q <= mo_dev;
      end
    end
  end

  assign mem_addr_o  = is_exec ? field : pc_q;
  assign mem_we_o    = is_exec && (op == OP_STO);
  assign mem_wdata_o = ac_q;
  assign running_o   = (state_q != ST_HALT);
  assign dev_en_o    = dev_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter  int ADDR_W = 16,
  localparam int DATA_W = ADDR_W + acc_pkg::OPC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              running_o,
  input logic [N_DEV-1:0]  dev_en_o,
  input logic [1:0]        state_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              ac_sign_i
);
  logic exec, is_jmp, is_halt_opr;

  assign exec        = (state_i == ST_EXEC);
  assign is_jmp      = (mem_rdata_i[DATA_W-1 -: 2] == OP_JMP);
  assign is_halt_opr = (mem_rdata_i[DATA_W-1 -: 2] == OP_OPR) && mem_rdata_i[MB_HLT];

  assert_we_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_jump_taken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && is_jmp && ac_sign_i) |=> (mem_addr_o == $past(mem_rdata_i[ADDR_W-1:0])));

  assert_pc_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !is_jmp && !is_halt_opr) |=> (mem_addr_o == $past(pc_i) + 1'b1));

  assert_no_write_halted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !mem_we_o);

  assert_stay_halted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !start_i) |=> !running_o);

  assert_dev_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> $stable(dev_en_o));

  assert_two_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |=> (state_i == ST_EXEC));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) i_acc_core_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_rdata_i (mem_rdata_i),
  .running_o   (running_o),
  .dev_en_o    (dev_en_o),
  .state_i     (state_q),
  .pc_i        (pc_q),
  .ac_sign_i   (ac_q[DATA_W-1])
);

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;
  localparam logic [1:0] STO = 2'b00, ADD = 2'b01, JMP = 2'b10, OPR = 2'b11;
  localparam logic [15:0] CLA = 16'h0001, CLL = 16'h0002, A2L = 16'h0004,
                          L2A = 16'h0008, CMA = 16'h0010, HLT = 16'h0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr;
  logic [17:0] wdata, rdata;
  logic        we, running;
  logic [4:0]  dev;

  logic [17:0] mem [0:1023];
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [17:0] ld_data = '0;

  int checks = 0, failures = 0;
  int run_cnt = 0, we_cnt = 0, bad_we = 0;
  logic [9:0] pw;

  always #2.5 clk = ~clk;

  acc_core i_acc_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_rdata_i(rdata), .running_o(running), .dev_en_o(dev)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (we) mem[addr[9:0]] <= wdata;
    rdata <= mem[addr[9:0]];
  end

  always @(negedge clk) begin
    if (running) run_cnt++;
    if (we) we_cnt++;
    if (we && !running) bad_we++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ld(input logic [9:0] a, input logic [17:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put(input logic [1:0] op, input logic [15:0] f);
    ld(pw, {op, f});
    pw = pw + 1'b1;
  endtask

  task automatic clear_area();
    for (int i = 0; i < 48; i++) ld(10'(i), 18'h0);
    for (int i = 200; i < 208; i++) ld(10'(i), 18'h15555);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_area();
    @(negedge clk);
    rst_n = 1'b1;
    pw = '0;
  endtask

  // pulse start, wait for halt; returns cycles run and writes seen
  task automatic run(output int cyc, output int wr);
    int r0, w0, n;
    r0 = run_cnt; w0 = we_cnt; n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (running === 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk("R6", "halt reached", 32'(running), 32'(0));
    cyc = run_cnt - r0;
    wr  = we_cnt - w0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6", "running in reset", 32'(running), 0);
    chk("R6", "we in reset", 32'(we), 0);
    chk("R7", "dev in reset", 32'(dev), 0);
  endtask

  task automatic t_add_store();
    int cyc, wr;
    do_reset();
    ld(100, 18'd5); ld(101, 18'd7);
    put(OPR, CLA); put(ADD, 100); put(ADD, 101); put(STO, 200); put(OPR, HLT);
    run(cyc, wr);
    chk("R2", "5+7", 32'(mem[200]), 32'd12);
    chk("R3", "one write for one store", wr, 1);
    chk("R8", "5 instr cycles", cyc, 10);
  endtask

  task automatic t_ones_complement();
    int cyc, wr;
    do_reset();
    ld(100, 18'h3FFFE); ld(101, 18'd5); ld(102, 18'h3FFFA); ld(104, 18'h1FFFF); ld(105, 18'd1);
    put(OPR, CLA); put(ADD, 100); put(ADD, 101); put(STO, 200);
    put(ADD, 102); put(STO, 201);
    put(OPR, CLA); put(ADD, 101); put(ADD, 102); put(STO, 202);
    put(OPR, CLA); put(ADD, 104); put(ADD, 105); put(STO, 203);
    put(OPR, HLT);
    run(cyc, wr);
    chk("R2", "-1+5 end-around", 32'(mem[200]), 32'd4);
    chk("R2", "4+(-5)", 32'(mem[201]), 32'h3FFFE);
    chk("R2", "5+(-5) minus zero", 32'(mem[202]), 32'h3FFFF);
    chk("R2", "into sign bit", 32'(mem[203]), 32'h20000);
    chk("R3", "four stores", wr, 4);
  endtask

  task automatic t_jump();
    int cyc, wr;
    do_reset();
    ld(100, 18'h20000);
    put(OPR, CLA); put(ADD, 100); put(JMP, 20); put(STO, 200); put(OPR, HLT);
    pw = 20;
    put(STO, 201); put(OPR, CLA); put(JMP, 30); put(STO, 202); put(OPR, HLT);
    pw = 30;
    put(STO, 203); put(OPR, HLT);
    run(cyc, wr);
    chk("R4", "taken skips fallthrough", 32'(mem[200]), 32'h15555);
    chk("R4", "taken target runs", 32'(mem[201]), 32'h20000);
    chk("R4", "not taken falls through", 32'(mem[202]), 32'h0);
    chk("R4", "not taken target idle", 32'(mem[203]), 32'h15555);
    chk("R8", "8 instr cycles", cyc, 16);
    chk("R1", "opcode 00 writes", wr, 2);
  endtask

  task automatic t_microops();
    int cyc, wr;
    do_reset();
    ld(100, 18'h00123); ld(101, 18'd7); ld(102, 18'h00050);
    put(OPR, CLA); put(ADD, 100); put(OPR, A2L);
    put(OPR, CLA | L2A | CMA); put(STO, 200);
    put(OPR, CLA | A2L); put(ADD, 101); put(OPR, L2A); put(STO, 201);
    put(ADD, 102); put(OPR, A2L); put(OPR, CLA); put(ADD, 101);
    put(OPR, A2L | L2A); put(STO, 202); put(OPR, L2A); put(STO, 203);
    put(OPR, CLA | CMA); put(STO, 204);
    put(OPR, CLL | A2L); put(OPR, CLA); put(OPR, L2A); put(STO, 205);
    put(OPR, CLL); put(OPR, L2A); put(STO, 206);
    put(OPR, HLT);
    run(cyc, wr);
    chk("R5", "clear,copy,complement", 32'(mem[200]), 32'h3FEDC);
    chk("R5", "clear before copy to link", 32'(mem[201]), 32'h0);
    chk("R5", "swap ac side", 32'(mem[202]), 32'h50);
    chk("R5", "swap link side", 32'(mem[203]), 32'h7);
    chk("R5", "clear before complement", 32'(mem[204]), 32'h3FFFF);
    chk("R5", "link clear then copy", 32'(mem[205]), 32'h3FFFF);
    chk("R5", "link clear", 32'(mem[206]), 32'h0);
  endtask

  task automatic t_reset_clears();
    int cyc, wr;
    do_reset();
    put(STO, 200); put(OPR, L2A); put(STO, 201); put(OPR, HLT);
    run(cyc, wr);
    chk("R6", "ac cleared by reset", 32'(mem[200]), 0);
    chk("R6", "link cleared by reset", 32'(mem[201]), 0);
  endtask

  task automatic t_devices_resume();
    int cyc, wr, w0, b0;
    do_reset();
    put(OPR, 16'h0160 | HLT);
    put(OPR, 16'h0880 | HLT);
    put(OPR, 16'h8600 | HLT);
    put(STO, 202); put(OPR, HLT);
    run(cyc, wr);
    chk("R7", "on 0 and 2", 32'(dev), 32'h05);
    chk("R8", "single instr", cyc, 2);
    w0 = we_cnt; b0 = bad_we;
    repeat (20) @(negedge clk);
    chk("R6", "halted no writes", we_cnt - w0, 0);
    chk("R7", "held while halted", 32'(dev), 32'h05);
    run(cyc, wr);
    chk("R7", "on 1 off 0", 32'(dev), 32'h06);
    run(cyc, wr);
    chk("R7", "off wins over on", 32'(dev), 32'h0E);
    run(cyc, wr);
    chk("R6", "resume at next address", 32'(mem[202]), 0);
    chk("R6", "no write while halted", bad_we - b0, 0);
  endtask

  initial begin
    pw = '0;
    t_reset_state();
    t_add_store();
    t_ones_complement();
    t_jump();
    t_microops();
    t_reset_clears();
    t_devices_resume();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule